// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns parallel audio samples into a single serial data line with a matching word-select / frame-sync output. A clock generator elsewhere supplies a one-cycle tick, `shift_en`, for every falling edge of the bit clock. The block advances one bit position per tick and owns the frame timing, so the data line and the sync line always stay aligned.

Four framings are available: two-channel I2S, two-channel left-justified, multi-slot TDM with a one-bit data delay, and multi-slot TDM with no delay. Sample length, slot width, slot count, the width of the frame-sync pulse, mono duplication and the underrun fill policy are all set by static configuration inputs. These inputs are expected to change only while reset is held.

Samples arrive on a valid/ready port with one word per slot. The block raises `smp_ready` for exactly one cycle at the start of each slot that needs fresh data and shows the slot's channel number on `smp_chan`. If no sample is offered at that moment, the slot is an underrun: it is filled by the configured policy and the channel's underrun bit is pulsed.

Top module: `tdm_audio_tx`

## Requirements
- R1: `cfg_fmt` selects the framing.
  - 0 = I2S: `ws` is low for channel 0 and high for channel 1, and the data runs one tick behind `ws`.
  - 1 = left-justified: `ws` is high for channel 0 and low for channel 1, and the data is aligned with `ws`.
- R2: `cfg_dlen` selects the sample length L: 0→32, 1→24, 2→20, 3→18, 4→16, 5→16 compact, 6→8, 7→8 compact.
  - A sample is taken from `smp_data[L-1:0]`; higher bits are ignored.
  - The sample is sent MSB first from the first bit of its slot, and the remaining bits of the slot are 0.
- R3: Slot width S depends on `cfg_dlen` and `cfg_slot24`, and a two-channel frame is 2·S ticks long.
  - S is 32 for code 0.
  - For codes 1–3, S is 32 when `cfg_slot24`=0 and 24 when it is 1.
  - S is 16 for codes 4–5 and 8 for codes 6–7.
  - In TDM framings S is always 32 and `cfg_slot24` has no effect.
- R4: In TDM framings (`cfg_fmt` 2 = one-tick data delay, 3 = no delay), a frame holds N=`cfg_nch_m1`+1 slots of 32 ticks each, numbered 0..N-1.
- R5: In TDM framings, `ws` is a sync pulse that starts at the frame start. `cfg_fs_mode` sets its width: 0 = 32 ticks, 1 = N·16 ticks, 2 or 3 = one tick.
- R6: `smp_ready` is high only in a cycle with `shift_en` high in which a slot needing fresh data begins. `smp_chan` then gives that slot's number. A sample transfers when `smp_valid` is also high.
- R7: Underrun (`smp_ready` high, `smp_valid` low) fills the slot with zero when `cfg_udr_repeat`=0, or with that channel's previous word when it is 1.
  - In the following cycle, `underrun[ch]` is high for exactly one cycle.
- R8: With `cfg_mono`=1 (and a non-compact length), each odd slot requests no data and repeats the word of the even slot before it.
- R9: With a compact length (codes 5 and 7), one word feeds an even slot and the odd slot after it.
  - The even slot uses bits [L-1:0] and the odd slot uses bits [2L-1:L].
  - The odd slot requests no data.
  - A compact length takes precedence over `cfg_mono`.
- R10: `sdo` and `ws` are registered and change only on the clock edge that ends a cycle with `shift_en` high.
- R11: After reset, `sdo`, `ws` and `underrun` are 0, every channel's previous word is zero, and the next tick is the first bit of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | One-cycle tick per bit-clock falling edge |
| cfg_fmt | input | 2 | Framing select |
| cfg_dlen | input | 3 | Sample length code |
| cfg_slot24 | input | 1 | 24-bit slot for lengths 18/20/24 |
| cfg_nch_m1 | input | 3 | TDM slot count minus one |
| cfg_fs_mode | input | 2 | TDM sync pulse width |
| cfg_udr_repeat | input | 1 | Underrun fill: 0 zero, 1 previous word |
| cfg_mono | input | 1 | Duplicate even slot into next odd slot |
| smp_valid | input | 1 | Sample offered |
| smp_data | input | 32 | Sample word, right-aligned |
| smp_ready | output | 1 | Sample taken this cycle |
| smp_chan | output | 3 | Slot number of the current slot |
| sdo | output | 1 | Serial data |
| ws | output | 1 | Word select / frame sync |
| underrun | output | 8 | One-cycle per-channel underrun pulse |

## Verification
The bench sweeps the four framings with lengths from 8 to 32 bits. Both slot widths are used for mid-length samples, so an error in either the slot size or the data delay shows up as a bit-position mismatch against `ws`. TDM runs use one, three, four and eight slots with each sync width, which separates slot counting from the sync-pulse timing. Random gaps in `smp_valid` combined with each fill policy distinguish zero fill from per-channel repeat, and mono and compact runs show whether odd slots reuse the right word without issuing requests. Tick rates of one, two and three cycles show that the outputs move only on ticks.

// File: rtl/tdm_audio_tx_pkg.sv
// Shared encodings and length decoders for the serial audio transmitter.
package tdm_audio_tx_pkg;

    localparam int SLOT_MAX = 32;

    typedef enum logic [1:0] {
        FMT_I2S    = 2'd0,
        FMT_LJ     = 2'd1,
        FMT_TDM    = 2'd2,
        FMT_TDM_LJ = 2'd3
    } frame_fmt_e;

    typedef enum logic [1:0] {
        FS_SLOT  = 2'd0,
        FS_HALF  = 2'd1,
        FS_BIT   = 2'd2,
        FS_BIT_B = 2'd3
    } fs_width_e;

    // Sample length in bits for a length code.
    function automatic logic [5:0] sample_bits(input logic [2:0] code);
        case (code)
            3'd0:       return 6'd32;
            3'd1:       return 6'd24;
            3'd2:       return 6'd20;
            3'd3:       return 6'd18;
            3'd4, 3'd5: return 6'd16;
            default:    return 6'd8;
        endcase
    endfunction

    // Compact codes carry two samples per word.
    function automatic logic is_compact(input logic [2:0] code);
        return (code == 3'd5) || (code == 3'd7);
    endfunction

    // Slot width in bit ticks.
    function automatic logic [5:0] slot_bits(input logic [2:0] code,
                                             input logic       s24,
                                             input logic       tdm);
        if (tdm) return 6'd32;
        case (code)
            3'd0:             return 6'd32;
            3'd1, 3'd2, 3'd3: return s24 ? 6'd24 : 6'd32;
            3'd4, 3'd5:       return 6'd16;
            default:          return 6'd8;
        endcase
    endfunction

endpackage

// File: rtl/tdm_audio_tx_timer.sv
// Frame position counter. Derives the slot number, the slot-start flag and
// the next word-select / sync level. Assumes configuration is static
// outside reset.
module tdm_audio_tx_timer
    import tdm_audio_tx_pkg::*;
#(
    parameter int MAX_CH = 8,
    parameter int CH_W   = $clog2(MAX_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic [1:0]      fmt,
    input  logic [2:0]      dlen,
    input  logic            slot24,
    input  logic [CH_W-1:0] nch_m1,
    input  logic [1:0]      fs_mode,
    output logic [CH_W-1:0] slot_idx,
    output logic            slot_start,
    output logic            ws_nxt
);
    localparam int POS_W   = $clog2(MAX_CH * SLOT_MAX) + 1;
    localparam int SLOT_SH = $clog2(SLOT_MAX);
    localparam logic [POS_W-1:0] FULL_SLOT = POS_W'(SLOT_MAX);
    localparam logic [POS_W-1:0] ONE       = POS_W'(1);

    frame_fmt_e       fmt_e;
    logic             is_tdm, delayed, in_second, last_pos;
    logic [POS_W-1:0] pos_q, slot_len, frame_len, wpos, bit_pos;

    // Decode frame geometry and current position.
    always_comb begin
        fmt_e     = frame_fmt_e'(fmt);
        is_tdm    = fmt[1];
        slot_len  = POS_W'(slot_bits(dlen, slot24, is_tdm));
        frame_len = is_tdm ? ((POS_W'(nch_m1) + ONE) << SLOT_SH) : (slot_len << 1);
        last_pos  = (pos_q == frame_len - ONE);
        in_second = !is_tdm && (pos_q >= slot_len);
        bit_pos   = is_tdm ? (pos_q & (FULL_SLOT - ONE))
                           : (in_second ? pos_q - slot_len : pos_q);
        slot_idx  = is_tdm ? pos_q[SLOT_SH +: CH_W] : CH_W'(in_second);
        slot_start = (bit_pos == '0);
        delayed   = (fmt_e == FMT_I2S) || (fmt_e == FMT_TDM);
        wpos      = delayed ? (last_pos ? '0 : pos_q + ONE) : pos_q;
    end

    // Select the word-select / sync level for this position.
    always_comb begin
        case (fmt_e)
            FMT_I2S: ws_nxt = (wpos >= slot_len);
            FMT_LJ:  ws_nxt = (wpos < slot_len);
            default: begin
                case (fs_width_e'(fs_mode))
                    FS_SLOT: ws_nxt = (wpos < FULL_SLOT);
                    FS_HALF: ws_nxt = (wpos < (frame_len >> 1));
                    default: ws_nxt = (wpos == '0);
                endcase
            end
        endcase
    end

    // Advance one bit position per tick, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos_q <= '0;
        else if (shift_en) pos_q <= last_pos ? '0 : pos_q + ONE;
    end

endmodule

// File: rtl/tdm_audio_tx_fetch.sv
// Sample fetch and fill. Decides per slot whether a new word is requested,
// applies the underrun policy, serves odd slots in mono and compact modes,
// and presents the word MSB-aligned for the shifter.
module tdm_audio_tx_fetch
    import tdm_audio_tx_pkg::*;
#(
    parameter int MAX_CH = 8,
    parameter int CH_W   = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              slot_start,
    input  logic [CH_W-1:0]   slot_idx,
    input  logic [2:0]        dlen,
    input  logic              mono,
    input  logic              udr_repeat,
    input  logic              smp_valid,
    input  logic [SLOT_MAX-1:0] smp_data,
    output logic              smp_ready,
    output logic [SLOT_MAX-1:0] load_word,
    output logic [MAX_CH-1:0] underrun
);
    logic [SLOT_MAX-1:0] last_q [MAX_CH];
    logic [SLOT_MAX-1:0] pair_q, raw, src;
    logic [5:0]          len;
    logic                compact, odd_reuse, fetch;

    // Choose the word for the slot now starting.
    always_comb begin
        len       = sample_bits(dlen);
        compact   = is_compact(dlen);
        odd_reuse = (compact || mono) && slot_idx[0];
        fetch     = shift_en && slot_start && !odd_reuse;
        raw       = smp_valid ? smp_data : (udr_repeat ? last_q[slot_idx] : '0);
        src       = odd_reuse ? (compact ? (pair_q >> len) : pair_q) : raw;
        load_word = src << (6'd32 - len);
        smp_ready = fetch;
    end

    // Record the word per channel and raise the underrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_CH; i++) last_q[i] <= '0;
            pair_q   <= '0;
            underrun <= '0;
        end else begin
            underrun <= '0;
            if (fetch) begin
                last_q[slot_idx] <= raw;
                pair_q           <= raw;
                if (!smp_valid) underrun[slot_idx] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_audio_tx_shift.sv
// Output shifter. Loads the MSB-aligned word at each slot start and shifts
// zeros in behind it, so bits past the sample length are 0.
module tdm_audio_tx_shift
    import tdm_audio_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                slot_start,
    input  logic [SLOT_MAX-1:0] load_word,
    input  logic                ws_nxt,
    output logic                sdo,
    output logic                ws
);
    logic [SLOT_MAX-1:0] sh_q;

    // Drive one data bit and the sync level per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            sdo  <= 1'b0;
            ws   <= 1'b0;
        end else if (shift_en) begin
            ws <= ws_nxt;
            if (slot_start) begin
                sdo  <= load_word[SLOT_MAX-1];
                sh_q <= load_word << 1;
            end else begin
                sdo  <= sh_q[SLOT_MAX-1];
                sh_q <= sh_q << 1;
            end
        end
    end

endmodule

// File: rtl/tdm_audio_tx.sv
// Serial audio transmitter top: frame timer, sample fetch and output
// shifter. Assumes shift_en marks bit-clock falling edges and that
// configuration is held steady except during reset.
module tdm_audio_tx
    import tdm_audio_tx_pkg::*;
#(
    parameter int MAX_CH = 8,
    parameter int CH_W   = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [1:0]        cfg_fmt,
    input  logic [2:0]        cfg_dlen,
    input  logic              cfg_slot24,
    input  logic [CH_W-1:0]   cfg_nch_m1,
    input  logic [1:0]        cfg_fs_mode,
    input  logic              cfg_udr_repeat,
    input  logic              cfg_mono,
    input  logic              smp_valid,
    input  logic [31:0]       smp_data,
    output logic              smp_ready,
    output logic [CH_W-1:0]   smp_chan,
    output logic              sdo,
    output logic              ws,
    output logic [MAX_CH-1:0] underrun
);
    logic [CH_W-1:0]     slot_idx;
    logic                slot_start, ws_nxt;
    logic [SLOT_MAX-1:0] load_word;

    tdm_audio_tx_timer #(.MAX_CH(MAX_CH), .CH_W(CH_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .fmt(cfg_fmt), .dlen(cfg_dlen), .slot24(cfg_slot24),
        .nch_m1(cfg_nch_m1), .fs_mode(cfg_fs_mode),
        .slot_idx(slot_idx), .slot_start(slot_start), .ws_nxt(ws_nxt)
    );

    tdm_audio_tx_fetch #(.MAX_CH(MAX_CH), .CH_W(CH_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .slot_start(slot_start), .slot_idx(slot_idx), .dlen(cfg_dlen),
        .mono(cfg_mono), .udr_repeat(cfg_udr_repeat),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_ready(smp_ready), .load_word(load_word), .underrun(underrun)
    );

    tdm_audio_tx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .slot_start(slot_start), .load_word(load_word), .ws_nxt(ws_nxt),
        .sdo(sdo), .ws(ws)
    );

    assign smp_chan = slot_idx;

endmodule

// File: rtl/tdm_audio_tx_chk.sv
// Protocol checker for the serial audio transmitter, bound to the top.
module tdm_audio_tx_chk #(
    parameter int MAX_CH = 8,
    parameter int CH_W   = $clog2(MAX_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en,
    input logic              cfg_mono,
    input logic [2:0]        cfg_dlen,
    input logic              smp_valid,
    input logic              smp_ready,
    input logic [CH_W-1:0]   smp_chan,
    input logic              sdo,
    input logic              ws,
    input logic [MAX_CH-1:0] underrun
);
    // R10
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(sdo) && $stable(ws)));

    // R6
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> shift_en);

    // R7
    udr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|underrun) |-> $past(smp_ready && !smp_valid));

    // R7
    udr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(underrun));

    // R8
    mono_even_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mono && smp_ready) |-> !smp_chan[0]);

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!sdo && !ws && (underrun == '0)));

endmodule

bind tdm_audio_tx tdm_audio_tx_chk #(.MAX_CH(MAX_CH), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cfg_mono(cfg_mono),
    .cfg_dlen(cfg_dlen), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_chan(smp_chan), .sdo(sdo), .ws(ws), .underrun(underrun)
);

// File: tb/test_tdm_audio_tx.sv
// Self-checking bench with a behavioural per-tick model compared every clock.
module test_tdm_audio_tx;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, shift_en = 1'b0;
    logic [1:0]  cfg_fmt = '0, cfg_fs_mode = '0;
    logic [2:0]  cfg_dlen = '0, cfg_nch_m1 = '0;
    logic        cfg_slot24 = 1'b0, cfg_udr_repeat = 1'b0, cfg_mono = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        smp_ready, sdo, ws;
    logic [2:0]  smp_chan;
    logic [7:0]  underrun;

    tdm_audio_tx i_tdm_audio_tx (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cfg_fmt(cfg_fmt),
        .cfg_dlen(cfg_dlen), .cfg_slot24(cfg_slot24), .cfg_nch_m1(cfg_nch_m1),
        .cfg_fs_mode(cfg_fs_mode), .cfg_udr_repeat(cfg_udr_repeat),
        .cfg_mono(cfg_mono), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_ready(smp_ready), .smp_chan(smp_chan), .sdo(sdo), .ws(ws),
        .underrun(underrun)
    );

    int checks = 0, fails = 0;
    int pos;
    logic [31:0] last_m [8];
    logic [31:0] pair_m, cur_m, dat_lfsr, gap_lfsr;
    logic        e_sdo, e_ws;
    logic [7:0]  e_udr;

    function automatic int lenb(int d);
        case (d)
            0: return 32; 1: return 24; 2: return 20; 3: return 18;
            4, 5: return 16; default: return 8;
        endcase
    endfunction

    function automatic int slotw(int d, bit s24, bit tdm);
        if (tdm) return 32;
        if (d == 0) return 32;
        if (d <= 3) return s24 ? 24 : 32;
        if (d <= 5) return 16;
        return 8;
    endfunction

    function automatic logic [31:0] xs(logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
        return y;
    endfunction

    function void check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endfunction

    task automatic run_case(string tag, int fmt, int dlen, bit s24, int nchm1,
                            int fsm, bit rep, bit mono, int div, int gap, int ncyc);
        bit tdm = (fmt >= 2);
        int L = lenb(dlen);
        int S = slotw(dlen, s24, tdm);
        int F = tdm ? 32 * (nchm1 + 1) : 2 * S;
        bit compact = (dlen == 5) || (dlen == 7);
        bit delay = (fmt == 0) || (fmt == 2);
        @(negedge clk);
        rst_n = 1'b0; shift_en = 1'b0; smp_valid = 1'b0;
        cfg_fmt = 2'(fmt); cfg_dlen = 3'(dlen); cfg_slot24 = s24;
        cfg_nch_m1 = 3'(nchm1); cfg_fs_mode = 2'(fsm);
        cfg_udr_repeat = rep; cfg_mono = mono;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pos = 0; pair_m = '0; cur_m = '0; e_sdo = 0; e_ws = 0; e_udr = '0;
        for (int i = 0; i < 8; i++) last_m[i] = '0;
        // R11 reset state
        check("R11", "reset sdo", sdo, 0);
        check("R11", "reset ws", ws, 0);
        check("R11", "reset underrun", underrun, 0);
        for (int c = 0; c < ncyc; c++) begin
            int slot, b, w;
            bit odd, exp_rdy;
            if (c > 0) begin
                check({tag, " R10"}, "sdo", sdo, e_sdo);
                check({tag, " R10"}, "ws", ws, e_ws);
                check("R7", "underrun", underrun, e_udr);
            end
            shift_en = ((c % div) == 0);
            gap_lfsr = xs(gap_lfsr);
            smp_valid = (gap == 0) || ((gap_lfsr % gap) != 0);
            smp_data = dat_lfsr;
            #1;
            slot = pos / S; b = pos % S;
            odd = (compact || mono) && (slot % 2 == 1);
            exp_rdy = shift_en && (b == 0) && !odd;
            check("R6", "smp_ready", smp_ready, exp_rdy);
            if (exp_rdy) check("R6", "smp_chan", smp_chan, slot);
            e_udr = '0;
            if (shift_en) begin
                if (b == 0) begin
                    if (odd) cur_m = compact ? (pair_m >> L) : pair_m;
                    else begin
                        if (smp_valid) cur_m = smp_data;
                        else begin
                            cur_m = rep ? last_m[slot] : '0;
                            e_udr[slot] = 1'b1;
                        end
                        last_m[slot] = cur_m;
                        pair_m = cur_m;
                    end
                end
                e_sdo = (b < L) ? cur_m[L-1-b] : 1'b0;
                w = delay ? (pos + 1) % F : pos;
                if (fmt == 0)      e_ws = (w >= S);
                else if (fmt == 1) e_ws = (w < S);
                else if (fsm == 0) e_ws = (w < 32);
                else if (fsm == 1) e_ws = (w < F / 2);
                else               e_ws = (w == 0);
                pos = (pos + 1) % F;
            end
            if (exp_rdy && smp_valid) dat_lfsr = xs(dat_lfsr);
            @(negedge clk);
        end
        check({tag, " R10"}, "sdo end", sdo, e_sdo);
        check({tag, " R10"}, "ws end", ws, e_ws);
    endtask

    initial begin
        dat_lfsr = 32'h1234_5678;
        gap_lfsr = 32'h9E37_79B9;
        run_case("R1 R2 R3",    0, 4, 0, 0, 0, 0, 0, 2, 0, 400);
        run_case("R1 R3 R7",    1, 1, 1, 0, 0, 1, 0, 3, 4, 900);
        run_case("R2 R3",       0, 0, 0, 0, 0, 0, 0, 1, 0, 300);
        run_case("R4 R5 R7",    2, 2, 0, 7, 0, 1, 0, 2, 3, 2500);
        run_case("R4 R5 R8",    3, 6, 0, 2, 1, 0, 1, 2, 5, 1200);
        run_case("R5 R9",       2, 5, 0, 3, 2, 0, 0, 3, 6, 1600);
        run_case("R3 R7 R8",    1, 3, 0, 0, 0, 0, 1, 2, 3, 800);
        run_case("R9 R1",       0, 7, 0, 0, 0, 1, 0, 2, 4, 400);
        run_case("R5 R3 R4",    3, 1, 1, 0, 3, 0, 0, 2, 0, 400);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule